// File: doc/BRIEF.md
# Registered Two-Port Bus Exchanger

This block moves a word between two parallel ports, A and B, in either direction. Each direction has a storage register that a capture strobe loads. It also has a source select that forwards either the live word from the opposite port or the stored copy. A drive enable marks when the block owns the port. Each port is split into a data input, a data output and an output-enable flag, so the block needs no tri-state logic. The surrounding logic resolves each physical bus from the block's outputs and any outside drivers, and returns the resolved value on the port's input.

A capture strobe takes effect on its rising edge, which is detected against the block clock. The register it controls loads the opposite-facing bus on that clock edge, whatever the enables and selects are doing. When both directions are enabled and both selects choose live data, the block closes a loop between the two ports. A per-port keeper then holds the last word each bus carried, and each port re-drives what the other port last carried. A reset input that asserts asynchronously and releases synchronously clears both registers and both keepers.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A rising edge on `cap_ab_i`, seen at a clock edge, loads the resolved `a_i` into the A-to-B register at that edge. The stored word reaches `b_o` (stored select) after that edge.
- R2: A rising edge on `cap_ba_i` loads the resolved `b_i` into the B-to-A register in the same way. The stored word reaches `a_o` (stored select).
- R3: Capture is never gated. Registers load even while both ports are isolated and whatever the selects are.
- R4: A select value of 0 forwards the live word from the opposite port, and a value of 1 forwards the stored register. This holds for each direction on its own.
- R5: `b_oe_o` is high exactly when `oe_ab_i` is 1, and `a_oe_o` is high exactly when `oe_ba_n_i` is 0. With `oe_ab_i`=0 and `oe_ba_n_i`=1, neither port is driven.
- R6: Loop-back is both enables active with both selects 0. In loop-back, `b_o` carries the word A held on the last clock before entry and `a_o` carries the word B held then. Both outputs stay constant while loop-back lasts, and outside drivers on the ports have no effect.
- R7: If one direction forwards live data onto the other port and both strobes rise on the same clock, both registers hold the same word.
- R8: A driven output that is not in loop-back always equals either the live word or the stored word of its direction, and never any other value.
- R9: After reset, both registers read as zero through the stored selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Active-low reset, asynchronous assert |
| cap_ab_i | input | 1 | Capture strobe for the A-to-B register |
| cap_ba_i | input | 1 | Capture strobe for the B-to-A register |
| oe_ab_i | input | 1 | Drive enable for port B, active high |
| oe_ba_n_i | input | 1 | Drive enable for port A, active low |
| sel_ab_i | input | 1 | B-side source: 0 live A, 1 stored |
| sel_ba_i | input | 1 | A-side source: 0 live B, 1 stored |
| a_i | input | WIDTH | Resolved A bus value |
| a_o | output | WIDTH | Word the block drives onto A |
| a_oe_o | output | 1 | Block drives A |
| b_i | input | WIDTH | Resolved B bus value |
| b_o | output | WIDTH | Word the block drives onto B |
| b_oe_o | output | 1 | Block drives B |

## Verification
Capture and forwarding can fall in the same cycle. A strobe can rise while the same port is driven live from the other side, so the word loaded is the word being forwarded. A strobe can also rise while a stored select drives the register that is being reloaded. The bench provokes these cases by pulsing one or both strobes under every enable and select combination, and with random stimulus. It judges each cycle against a behavioural model that resolves both buses and updates its registers and keepers at the edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;

  function automatic src_e decode_sel(input logic sel);
    return sel ? SRC_STORED : SRC_LIVE;
  endfunction
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST:0], 1'b1} >> 1;
    chain_d[LAST] = chain_q[LAST];
    for (int i = LAST; i > 0; i--) chain_d[i] = chain_q[i-1];
    chain_d[0] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[LAST];
endmodule

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             strobe_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic             strobe_q;
  logic             load;
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] word_d;

  assign load = strobe_i & ~strobe_q;

  always_comb begin
    word_d = word_q;
    if (load) word_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      strobe_q <= 1'b0;
      word_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      word_q   <= word_d;
    end
  end

  assign q_o = word_q;

  // R1 / R2: a strobe rising edge loads the presented word
  p_load_r1_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (strobe_i && !strobe_q) |=> (q_o == $past(d_i)));

  // R3: without a rising edge the stored word holds
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(strobe_i && !strobe_q) |=> $stable(q_o));
endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             hold_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] held_q;
  logic [WIDTH-1:0] held_d;

  always_comb begin
    held_d = held_q;
    if (!hold_i) held_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) held_q <= '0;
    else          held_q <= held_d;
  end

  assign q_o = held_q;

  // R6: the keeper freezes while the loop is closed
  p_keep_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    hold_i |=> $stable(q_o));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             en_i,
  input  logic             sel_i,
  input  logic             loop_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  input  logic [WIDTH-1:0] held_i,
  output logic [WIDTH-1:0] data_o,
  output logic             oe_o
);
  src_e src;

  always_comb begin
    src = decode_sel(sel_i);
    if (loop_i)                  data_o = held_i;
    else if (src == SRC_STORED)  data_o = stored_i;
    else                         data_o = live_i;
    oe_o = en_i;
  end
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             cap_ab_i,
  input  logic             cap_ba_i,
  input  logic             oe_ab_i,
  input  logic             oe_ba_n_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);
  logic             rst_n_q;
  logic             en_a;
  logic             en_b;
  logic             loop;
  logic [WIDTH-1:0] ab_q;
  logic [WIDTH-1:0] ba_q;
  logic [WIDTH-1:0] keep_a_q;
  logic [WIDTH-1:0] keep_b_q;

  assign en_b = oe_ab_i;
  assign en_a = ~oe_ba_n_i;
  assign loop = en_a & en_b & ~sel_ab_i & ~sel_ba_i;

  xcvr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .rst_n_o(rst_n_q)
  );

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_ab (
    .clk_i(clk_i), .rst_n_i(rst_n_q), .strobe_i(cap_ab_i), .d_i(a_i), .q_o(ab_q)
  );

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_ba (
    .clk_i(clk_i), .rst_n_i(rst_n_q), .strobe_i(cap_ba_i), .d_i(b_i), .q_o(ba_q)
  );

  xcvr_keeper #(.WIDTH(WIDTH)) u_keep_a (
    .clk_i(clk_i), .rst_n_i(rst_n_q), .hold_i(loop), .d_i(a_i), .q_o(keep_a_q)
  );

  xcvr_keeper #(.WIDTH(WIDTH)) u_keep_b (
    .clk_i(clk_i), .rst_n_i(rst_n_q), .hold_i(loop), .d_i(b_i), .q_o(keep_b_q)
  );

  xcvr_drive #(.WIDTH(WIDTH)) u_drv_b (
    .en_i(en_b), .sel_i(sel_ab_i), .loop_i(loop), .live_i(a_i),
    .stored_i(ab_q), .held_i(keep_a_q), .data_o(b_o), .oe_o(b_oe_o)
  );

  xcvr_drive #(.WIDTH(WIDTH)) u_drv_a (
    .en_i(en_a), .sel_i(sel_ba_i), .loop_i(loop), .live_i(b_i),
    .stored_i(ba_q), .held_i(keep_b_q), .data_o(a_o), .oe_o(a_oe_o)
  );

  // R8: a driven port shows one of its two sources only
  p_src_b_r8: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (b_oe_o && !loop) |-> (b_o == a_i || b_o == ab_q));
  p_src_a_r8: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (a_oe_o && !loop) |-> (a_o == b_i || a_o == ba_q));

  // R6: outputs hold steady for as long as the loop stays closed
  p_loop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (loop && $past(loop)) |-> ($stable(a_o) && $stable(b_o)));

  // R5: isolation leaves both ports undriven
  p_iso_r5: assert property (@(posedge clk_i) disable iff (!rst_n_q)
    (!oe_ab_i && oe_ba_n_i) |-> (!a_oe_o && !b_oe_o));
endmodule

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int W = 8;
  localparam int CLK_PERIOD = 20;

  logic clk = 1'b0;
  logic rst_n;
  logic cap_ab, cap_ba, oe_ab, oe_ba_n, sel_ab, sel_ba;
  logic [W-1:0] a_i, b_i, a_o, b_o;
  logic a_oe, b_oe;
  logic [W-1:0] ext_a, ext_b;

  int n_run = 0;
  int n_fail = 0;

  // behavioural model state
  logic [W-1:0] m_ab, m_ba, m_ka, m_kb, va, vb;
  logic pcab, pcba;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) dut (
    .clk_i(clk), .rst_n_i(rst_n), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .oe_ab_i(oe_ab), .oe_ba_n_i(oe_ba_n), .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .a_i(a_i), .a_o(a_o), .a_oe_o(a_oe), .b_i(b_i), .b_o(b_o), .b_oe_o(b_oe)
  );

  function automatic bit in_loop();
    return oe_ab && !oe_ba_n && !sel_ab && !sel_ba;
  endfunction

  // resolve both buses in the model
  task automatic model_bus();
    logic [W-1:0] ea, eb;
    va = ext_a; vb = ext_b;
    for (int i = 0; i < 3; i++) begin
      ea = in_loop() ? m_kb : (sel_ba ? m_ba : vb);
      eb = in_loop() ? m_ka : (sel_ab ? m_ab : va);
      va = !oe_ba_n ? ea : ext_a;
      vb = oe_ab ? eb : ext_b;
    end
  endtask

  // resolve the real buses from the design's outputs
  task automatic settle();
    for (int i = 0; i < 4; i++) begin
      #1;
      a_i = a_oe ? a_o : ext_a;
      b_i = b_oe ? b_o : ext_b;
    end
  endtask

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit cab, bit cba, bit oab, bit obn,
                      bit sab, bit sba, logic [W-1:0] xa, logic [W-1:0] xb);
    bit lp;
    @(negedge clk);
    cap_ab = cab; cap_ba = cba; oe_ab = oab; oe_ba_n = obn;
    sel_ab = sab; sel_ba = sba; ext_a = xa; ext_b = xb;
    settle();
    model_bus();
    lp = in_loop();
    @(posedge clk);
    if (cab && !pcab) m_ab = va;
    if (cba && !pcba) m_ba = vb;
    pcab = cab; pcba = cba;
    if (!lp) begin m_ka = va; m_kb = vb; end
    #1;
    settle();
    model_bus();
    chk(tag, "b_oe", {7'd0, b_oe}, {7'd0, oab});
    chk(tag, "a_oe", {7'd0, a_oe}, {7'd0, !obn});
    if (oab) chk(tag, "b_o", b_o, vb);
    if (!obn) chk(tag, "a_o", a_o, va);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cap_ab = 0; cap_ba = 0; oe_ab = 0; oe_ba_n = 1; sel_ab = 0; sel_ba = 0;
    ext_a = '0; ext_b = '0; a_i = '0; b_i = '0;
    m_ab = '0; m_ba = '0; m_ka = '0; m_kb = '0; pcab = 0; pcba = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) step("R9", 0, 0, 0, 1, 0, 0, 8'h00, 8'h00);

    // R9: stored words after reset are zero
    step("R9", 0, 0, 1, 0, 1, 1, 8'h00, 8'h00);
    chk("R9", "b_o reset", b_o, 8'h00);
    chk("R9", "a_o reset", a_o, 8'h00);

    // R5: isolation
    step("R5", 0, 0, 0, 1, 1, 0, 8'h3C, 8'hA5);
    chk("R5", "iso oe", {6'd0, a_oe, b_oe}, 8'h00);

    // R1 and R2 captures while isolated (R3)
    step("R1", 1, 0, 0, 1, 0, 1, 8'h3C, 8'hA5);
    step("R1", 0, 0, 0, 1, 0, 1, 8'h00, 8'h00);
    step("R2", 0, 1, 0, 1, 1, 0, 8'h00, 8'hA5);
    step("R2", 0, 0, 0, 1, 1, 0, 8'h00, 8'h00);
    step("R4", 0, 0, 1, 1, 1, 0, 8'h00, 8'h00);
    chk("R1", "stored ab", b_o, 8'h3C);
    step("R4", 0, 0, 0, 0, 0, 1, 8'h00, 8'h00);
    chk("R2", "stored ba", a_o, 8'hA5);

    // R4: live forwarding each direction
    step("R4", 0, 0, 1, 1, 0, 0, 8'h5A, 8'h00);
    chk("R4", "live a->b", b_o, 8'h5A);
    step("R4", 0, 0, 0, 0, 0, 0, 8'h00, 8'h96);
    chk("R4", "live b->a", a_o, 8'h96);

    // R3: capture with selects stored and enables off, then show it
    step("R3", 1, 0, 0, 1, 1, 1, 8'h0F, 8'hF0);
    step("R3", 0, 0, 1, 1, 1, 1, 8'h00, 8'h00);
    chk("R3", "ungated capture", b_o, 8'h0F);

    // R7: simultaneous strobes under live A->B drive
    step("R7", 1, 1, 1, 1, 0, 0, 8'hC3, 8'h00);
    step("R7", 0, 0, 1, 0, 1, 1, 8'h00, 8'h00);
    chk("R7", "ab word", b_o, 8'hC3);
    chk("R7", "ba word", a_o, 8'hC3);

    // R6: loop-back from isolation with differing buses
    step("R6", 0, 0, 0, 1, 0, 0, 8'h11, 8'h22);
    step("R6", 0, 0, 1, 0, 0, 0, 8'h99, 8'h88);
    chk("R6", "loop b_o", b_o, 8'h11);
    chk("R6", "loop a_o", a_o, 8'h22);
    step("R6", 0, 0, 1, 0, 0, 0, 8'h44, 8'h55);
    chk("R6", "loop hold b_o", b_o, 8'h11);
    chk("R6", "loop hold a_o", a_o, 8'h22);
    step("R6", 0, 0, 1, 1, 0, 0, 8'h77, 8'h00);
    step("R6", 0, 0, 1, 0, 0, 0, 8'h00, 8'h00);
    chk("R6", "loop same b_o", b_o, 8'h77);
    chk("R6", "loop same a_o", a_o, 8'h77);

    // R8: select toggling with distinct live and stored words
    for (int i = 0; i < 8; i++) begin
      step("R8", 0, 0, 1, 1, i[0], 0, 8'h10 + 8'(i), 8'h00);
      chk("R8", "toggle", b_o, i[0] ? 8'hC3 : 8'h10 + 8'(i));
    end

    // staggered loads with both stored selects driving
    step("R1", 1, 0, 1, 0, 1, 1, 8'h00, 8'h00);
    step("R2", 0, 1, 1, 0, 1, 1, 8'h00, 8'h00);

    // random mix judged by the model
    for (int i = 0; i < 400; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      step("R4", r[0], r[1], r[2], r[3], r[4], r[5], 8'($urandom), 8'($urandom));
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule